// File: doc/BRIEF.md
# Memory address protection unit

This block sits on the address path between a processor core and its memory. Each cycle it can accept one request made of a virtual address, an access kind (instruction fetch, data read or data write) and a privilege bit. One cycle later it presents either a checked effective address with a valid strobe, or a fault strobe. Supervisor requests pass through untouched. User requests are confined by one of two schemes, chosen by a control bit. Sandbox mode overwrites the segment field of the address by an AND with a clearing mask and an OR with an inserting mask. Relative mode adds a base register to the user's offset and refuses results that fall under a floor or reach a fence. Relative mode has separate base, floor and fence registers for instruction fetches and for data accesses.

The protection registers are loaded through a small write port, and only a supervisor may load them. When an access or a configuration attempt is refused, a sticky fault record takes its cause and the offending address. It keeps them until a supervisor clears it. The reset input is asserted asynchronously and released through a two-stage synchroniser.

Top module: `addr_guard`

## Requirements
- R1: During reset and after it, mem_valid, mem_fault and fault_flag are 0. The block starts in sandbox mode with segment identifier 0, and every base, floor and fence register holds 0.
- R2: A request sampled at a rising edge drives its result on the outputs right after that edge. One register stage lies between them. A cycle with req_valid low gives mem_valid=0, mem_fault=0 and mem_addr=0.
- R3: In sandbox mode (control bit 0 = 0), a user access yields {segment identifier, req_addr[23:0]}. The segment field is the top 8 bits. Sandbox mode never faults.
- R4: A supervisor access (req_super=1) passes req_addr unchanged and never faults, in both modes.
- R5: In relative mode (control bit 0 = 1), a user access yields base + req_addr. It uses the program set for req_kind 0 (fetch) and the data set for req_kind 1 (read), 2 (write) and 3 (handled as data).
- R6: A relative user access whose sum is below its set's floor faults with cause 1. A sum equal to the floor is accepted.
- R7: A relative user access whose sum is at or above its set's fence, or whose addition carries out of 32 bits, faults with cause 2. The floor test has priority. A sum of fence-1 is accepted.
- R8: A faulting access drives mem_fault=1, mem_valid=0 and mem_addr=0.
- R9: A write with cfg_we=1 and cfg_super=1 updates the register picked by cfg_sel, and the new value applies from the next cycle. A request in the same cycle still uses the old values. The cfg_sel map: 0 control (bit0 mode, bit1 clears the fault record and is not stored), 1 segment identifier (low 8 bits), 2 program base, 3 program floor, 4 program fence, 5 data base, 6 data floor, 7 data fence. A write with cfg_super=0 changes no register.
- R10: The fault record captures the first refusal while fault_flag is 0. For an access it stores the cause and req_addr. For a user configuration write it stores cause 3 and cfg_sel zero-extended. While fault_flag is 1 the record does not change until a supervisor control write with bit1 set. A refusal in the same cycle as that clear is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Virtual address or offset |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 treated as data |
| req_super | input | 1 | Request issued in supervisor mode |
| cfg_we | input | 1 | Protection register write strobe |
| cfg_super | input | 1 | Writer is in supervisor mode |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Write data |
| mem_valid | output | 1 | Checked address valid toward memory |
| mem_addr | output | 32 | Effective address, zero on fault |
| mem_fault | output | 1 | Access refused |
| fault_flag | output | 1 | Fault record occupied |
| fault_cause | output | 2 | 1 under floor, 2 fence or carry, 3 user config write |
| fault_addr | output | 32 | Offending address or register select |

## Verification
The bench goes after the exact edges of the relative window: a sum equal to the floor, a sum one below the fence, a sum equal to the fence, and an offset large enough to carry out of 32 bits. An off-by-one compare would refuse a legal edge address or let the first fence address through. A dropped carry would wrap a huge offset back into user space. The bench also checks which register set serves each access kind, so that a swapped program and data selection shows up as a wrong address. It checks that a user configuration write leaves the segment identifier intact. A design that honoured the write would shift every later sandboxed address. The bench also checks that a second fault leaves the stored record unchanged, that a request in the same cycle as a register write still sees the old base, and that a clear in the same cycle as a fault keeps the new fault.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;
  localparam int unsigned CFG_SEL_W = 3;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_OTHER = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_FLOOR = 2'd1,
    CAUSE_FENCE = 2'd2,
    CAUSE_CFG   = 2'd3
  } cause_e;
endpackage

// File: rtl/addr_guard_regs.sv
module addr_guard_regs
  import addr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SEG_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic                      cfg_super,
  input  logic [CFG_SEL_W-1:0]      cfg_sel,
  input  logic [ADDR_W-1:0]         cfg_wdata,
  output logic                      mode_rel,
  output logic [SEG_W-1:0]          seg_id,
  output logic [1:0][ADDR_W-1:0]    win_base,
  output logic [1:0][ADDR_W-1:0]    win_floor,
  output logic [1:0][ADDR_W-1:0]    win_fence,
  output logic                      clr_req,
  output logic                      cfg_refused
);
  logic             wr_ok;
  logic             mode_d, mode_q;
  logic [SEG_W-1:0] seg_d, seg_q;

  assign wr_ok       = cfg_we & cfg_super;
  assign cfg_refused = cfg_we & ~cfg_super;
  assign clr_req     = wr_ok & (cfg_sel == CFG_SEL_W'(0)) & cfg_wdata[1];

  always_comb begin
    mode_d = mode_q;
    seg_d  = seg_q;
    if (wr_ok && cfg_sel == CFG_SEL_W'(0)) mode_d = cfg_wdata[0];
    if (wr_ok && cfg_sel == CFG_SEL_W'(1)) seg_d  = cfg_wdata[SEG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      seg_q  <= '0;
    end else begin
      mode_q <= mode_d;
      seg_q  <= seg_d;
    end
  end

  assign mode_rel = mode_q;
  assign seg_id   = seg_q;

  // window 0 serves fetches, window 1 serves data accesses
  for (genvar w = 0; w < 2; w++) begin : g_win
    localparam int unsigned SEL_BASE = 2 + 3 * w;
    logic [ADDR_W-1:0] base_d, base_q, floor_d, floor_q, fence_d, fence_q;

    always_comb begin
      base_d  = base_q;
      floor_d = floor_q;
      fence_d = fence_q;
      if (wr_ok && cfg_sel == CFG_SEL_W'(SEL_BASE))     base_d  = cfg_wdata;
      if (wr_ok && cfg_sel == CFG_SEL_W'(SEL_BASE + 1)) floor_d = cfg_wdata;
      if (wr_ok && cfg_sel == CFG_SEL_W'(SEL_BASE + 2)) fence_d = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q  <= '0;
        floor_q <= '0;
        fence_q <= '0;
      end else begin
        base_q  <= base_d;
        floor_q <= floor_d;
        fence_q <= fence_d;
      end
    end

    assign win_base[w]  = base_q;
    assign win_floor[w] = floor_q;
    assign win_fence[w] = fence_q;
  end

  // R9
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_super) |=> ($stable(mode_rel) && $stable(seg_id) &&
      $stable(win_base) && $stable(win_floor) && $stable(win_fence)));
endmodule

// File: rtl/addr_guard_xlate.sv
module addr_guard_xlate
  import addr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SEG_W  = 8
) (
  input  logic                   mode_rel,
  input  logic [SEG_W-1:0]       seg_id,
  input  logic [1:0][ADDR_W-1:0] win_base,
  input  logic [1:0][ADDR_W-1:0] win_floor,
  input  logic [1:0][ADDR_W-1:0] win_fence,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_kind,
  input  logic                   req_super,
  output logic [ADDR_W-1:0]      eff_addr,
  output cause_e                 cause
);
  localparam int unsigned OFF_W = ADDR_W - SEG_W;
  localparam logic [ADDR_W-1:0] KEEP_MASK = {{SEG_W{1'b0}}, {OFF_W{1'b1}}};

  logic              use_data;
  logic [ADDR_W-1:0] ins_mask, sandboxed, sum;
  logic              carry;

  assign use_data  = (acc_kind_e'(req_kind) != ACC_FETCH);
  assign ins_mask  = {seg_id, {OFF_W{1'b0}}};
  assign sandboxed = (req_addr & KEEP_MASK) | ins_mask;
  assign {carry, sum} = {1'b0, win_base[use_data]} + {1'b0, req_addr};

  always_comb begin
    eff_addr = req_addr;
    cause    = CAUSE_NONE;
    if (!req_super) begin
      if (!mode_rel) begin
        eff_addr = sandboxed;
      end else begin
        eff_addr = sum;
        if (sum < win_floor[use_data])                  cause = CAUSE_FLOOR;
        else if (carry || sum >= win_fence[use_data])   cause = CAUSE_FENCE;
      end
    end
  end
endmodule

// File: rtl/addr_guard.sv
module addr_guard
  import addr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SEG_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_kind,
  input  logic                 req_super,
  input  logic                 cfg_we,
  input  logic                 cfg_super,
  input  logic [CFG_SEL_W-1:0] cfg_sel,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  output logic                 mem_valid,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_fault,
  output logic                 fault_flag,
  output logic [1:0]           fault_cause,
  output logic [ADDR_W-1:0]    fault_addr
);
  logic [1:0]             rst_sync_q;
  logic                   rst_int_n;
  logic                   mode_rel, clr_req, cfg_refused;
  logic [SEG_W-1:0]       seg_id;
  logic [1:0][ADDR_W-1:0] win_base, win_floor, win_fence;
  logic [ADDR_W-1:0]      eff_addr;
  cause_e                 cause;
  logic                   acc_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  addr_guard_regs #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_super(cfg_super),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .mode_rel(mode_rel), .seg_id(seg_id),
    .win_base(win_base), .win_floor(win_floor), .win_fence(win_fence),
    .clr_req(clr_req), .cfg_refused(cfg_refused)
  );

  addr_guard_xlate #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_xlate (
    .mode_rel(mode_rel), .seg_id(seg_id), .win_base(win_base), .win_floor(win_floor),
    .win_fence(win_fence), .req_addr(req_addr), .req_kind(req_kind),
    .req_super(req_super), .eff_addr(eff_addr), .cause(cause)
  );

  assign acc_fault = req_valid & (cause != CAUSE_NONE);

  logic              valid_d, fault_d, flag_d;
  logic [ADDR_W-1:0] addr_d, faddr_d;
  logic [1:0]        fcause_d;

  always_comb begin
    valid_d  = req_valid & ~acc_fault;
    fault_d  = acc_fault;
    addr_d   = valid_d ? eff_addr : '0;
    flag_d   = clr_req ? 1'b0 : fault_flag;
    fcause_d = fault_cause;
    faddr_d  = fault_addr;
    if (!flag_d) begin
      if (acc_fault) begin
        flag_d   = 1'b1;
        fcause_d = cause;
        faddr_d  = req_addr;
      end else if (cfg_refused) begin
        flag_d   = 1'b1;
        fcause_d = CAUSE_CFG;
        faddr_d  = ADDR_W'(cfg_sel);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mem_valid   <= 1'b0;
      mem_fault   <= 1'b0;
      mem_addr    <= '0;
      fault_flag  <= 1'b0;
      fault_cause <= 2'd0;
      fault_addr  <= '0;
    end else begin
      mem_valid   <= valid_d;
      mem_fault   <= fault_d;
      mem_addr    <= addr_d;
      fault_flag  <= flag_d;
      fault_cause <= fcause_d;
      fault_addr  <= faddr_d;
    end
  end

  // R2
  result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_valid || mem_fault) |-> $past(req_valid));

  // R8
  fault_hides_addr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_fault |-> (!mem_valid && mem_addr == '0));

  // R3
  sandbox_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_fault |-> $past(mode_rel));

  // R10
  record_holds_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fault_flag && !clr_req) |=> (fault_flag && $stable(fault_addr) && $stable(fault_cause)));
endmodule

// File: tb/addr_guard_bench.sv
module addr_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_super, cfg_we, cfg_super;
  logic [31:0] req_addr, cfg_wdata;
  logic [1:0]  req_kind;
  logic [2:0]  cfg_sel;
  logic        mem_valid, mem_fault, fault_flag;
  logic [31:0] mem_addr, fault_addr;
  logic [1:0]  fault_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_guard u_addr_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_super(req_super), .cfg_we(cfg_we), .cfg_super(cfg_super),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_fault(mem_fault), .fault_flag(fault_flag), .fault_cause(fault_cause),
    .fault_addr(fault_addr)
  );

  typedef struct {
    string       tag;
    bit          v, f, sf;
    logic [31:0] a, sa;
    logic [1:0]  sc;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;

  // reference state, kept from the requirements
  bit          m_rel;
  logic [7:0]  m_seg;
  logic [31:0] m_base[2], m_floor[2], m_fence[2];
  bit          s_flag;
  logic [1:0]  s_cause;
  logic [31:0] s_addr;

  task automatic step(input string tag, input bit v, input logic [31:0] a,
                      input logic [1:0] k, input bit sup, input bit we,
                      input logic [2:0] sel, input logic [31:0] wd, input bit wsup);
    exp_t e;
    int unsigned w;
    logic [32:0] s;
    logic [31:0] eff;
    logic [1:0]  c;
    @(negedge clk);
    req_valid = v; req_addr = a; req_kind = k; req_super = sup;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd; cfg_super = wsup;
    w = (k != 2'd0) ? 1 : 0;
    eff = a; c = 2'd0;
    if (!sup) begin
      if (!m_rel) eff = {m_seg, a[23:0]};
      else begin
        s = {1'b0, m_base[w]} + {1'b0, a};
        eff = s[31:0];
        if (s[31:0] < m_floor[w]) c = 2'd1;
        else if (s[32] || s[31:0] >= m_fence[w]) c = 2'd2;
      end
    end
    e.tag = tag;
    e.f = v && (c != 2'd0);
    e.v = v && !e.f;
    e.a = e.v ? eff : 32'd0;
    if (we && wsup && sel == 3'd0 && wd[1]) s_flag = 0;
    if (!s_flag) begin
      if (e.f) begin s_flag = 1; s_cause = c; s_addr = a; end
      else if (we && !wsup) begin s_flag = 1; s_cause = 2'd3; s_addr = {29'd0, sel}; end
    end
    e.sf = s_flag; e.sc = s_cause; e.sa = s_addr;
    if (we && wsup) begin
      case (sel)
        3'd0: m_rel = wd[0];
        3'd1: m_seg = wd[7:0];
        3'd2: m_base[0] = wd;
        3'd3: m_floor[0] = wd;
        3'd4: m_fence[0] = wd;
        3'd5: m_base[1] = wd;
        3'd6: m_floor[1] = wd;
        default: m_fence[1] = wd;
      endcase
    end
    q.push_back(e);
  endtask

  task automatic acc(input string tag, input logic [31:0] a, input logic [1:0] k, input bit sup);
    step(tag, 1, a, k, sup, 0, 3'd0, 32'd0, 0);
  endtask

  task automatic cfg(input string tag, input logic [2:0] sel, input logic [31:0] wd, input bit wsup);
    step(tag, 0, 32'd0, 2'd0, 0, 1, sel, wd, wsup);
  endtask

  // monitor: the result for the request driven at the previous falling edge
  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (mem_valid !== e.v || mem_fault !== e.f || mem_addr !== e.a ||
          fault_flag !== e.sf || (e.sf && (fault_cause !== e.sc || fault_addr !== e.sa))) begin
        fails++;
        $display("FAIL %s: got v=%0b f=%0b a=%h rec=%0b/%0d/%h, expected v=%0b f=%0b a=%h rec=%0b/%0d/%h",
                 e.tag, mem_valid, mem_fault, mem_addr, fault_flag, fault_cause, fault_addr,
                 e.v, e.f, e.a, e.sf, e.sc, e.sa);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_addr = '0; req_kind = '0; req_super = 0;
    cfg_we = 0; cfg_sel = '0; cfg_wdata = '0; cfg_super = 0;
    m_rel = 0; m_seg = '0; s_flag = 0; s_cause = '0; s_addr = '0;
    for (int i = 0; i < 2; i++) begin m_base[i] = '0; m_floor[i] = '0; m_fence[i] = '0; end
    repeat (3) @(negedge clk);
    checks++;
    if (mem_valid !== 0 || mem_fault !== 0 || fault_flag !== 0) begin
      fails++;
      $display("FAIL R1 in reset: got v=%0b f=%0b rec=%0b, expected 0 0 0", mem_valid, mem_fault, fault_flag);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (mem_valid !== 0 || mem_fault !== 0 || fault_flag !== 0) begin
      fails++;
      $display("FAIL R1 after reset: got v=%0b f=%0b rec=%0b, expected 0 0 0", mem_valid, mem_fault, fault_flag);
    end

    acc("R1 R3 sandbox seg 0", 32'hABCD1234, 2'd1, 0);
    step("R2 idle cycle", 0, 32'hFFFFFFFF, 2'd1, 0, 0, 3'd0, 32'd0, 0);
    cfg("R9 set seg", 3'd1, 32'h0000005A, 1);
    acc("R3 sandbox fetch", 32'h12345678, 2'd0, 0);
    acc("R3 sandbox write", 32'hFFFFFFFF, 2'd2, 0);
    acc("R4 supervisor sandbox", 32'hFFFF0000, 2'd1, 1);
    cfg("R9 R10 user cfg refused", 3'd1, 32'h00000011, 0);
    acc("R9 seg kept", 32'h00000010, 2'd1, 0);
    cfg("R9 prog base", 3'd2, 32'h00001000, 1);
    cfg("R9 prog floor", 3'd3, 32'h00001000, 1);
    cfg("R9 prog fence", 3'd4, 32'h00002000, 1);
    cfg("R9 data base", 3'd5, 32'h00008000, 1);
    cfg("R9 data floor", 3'd6, 32'h00008100, 1);
    cfg("R9 data fence", 3'd7, 32'h00009000, 1);
    cfg("R10 clear and relative", 3'd0, 32'h00000003, 1);
    acc("R5 fetch program set", 32'h00000010, 2'd0, 0);
    acc("R5 read data set", 32'h00000200, 2'd1, 0);
    acc("R5 kind3 data set", 32'h00000300, 2'd3, 0);
    acc("R6 R8 under floor", 32'h00000050, 2'd1, 0);
    acc("R7 R10 data at fence, record kept", 32'h00001000, 2'd2, 0);
    acc("R7 fetch at fence", 32'h00001000, 2'd0, 0);
    acc("R7 carry out", 32'hFFFFFFFF, 2'd1, 0);
    acc("R7 one below fence", 32'h00000FFF, 2'd1, 0);
    acc("R6 equal to floor", 32'h00000100, 2'd1, 0);
    acc("R4 supervisor relative", 32'h00000050, 2'd1, 1);
    step("R9 old base same cycle", 1, 32'h00000010, 2'd0, 0, 1, 3'd2, 32'h00001800, 1);
    acc("R9 new base", 32'h00000010, 2'd0, 0);
    step("R10 clear with new fault", 1, 32'h00000040, 2'd1, 0, 1, 3'd0, 32'h00000003, 1);
    acc("R10 record after clear", 32'h00000020, 2'd1, 0);
    step("R2 idle end", 0, 32'd0, 2'd0, 0, 0, 3'd0, 32'd0, 0);
    @(posedge clk); #2;
    finish_run();
  end
endmodule